// File: doc/BRIEF.md
# Dual-Port Segmented Memory Access Controller

This block connects two byte-oriented transaction front ends to one shared 1024-byte memory. One front end is a display-side port and the other is a host-side port. The bit-level serial signalling is handled outside the block. Each front end presents already-decoded byte operations: an 8-bit device code, an 8-bit data byte, an offset load, and an end-of-transaction pulse. The block answers each operation with a one-cycle acknowledge.

The two ports see different maps of the same array. The display port sees four 256-byte segments laid out as one flat 1024-byte space. The host port sees a single 512-byte bank made of two segments. A configuration register and an external select pin together choose which bank that is.

Each port keeps its own segment pointer and its own byte offset. The block also gates host writes with an enable bit, and it arbitrates the single-cycle memory slots between the two ports.

Top module: `segmem_access_ctrl`

## Requirements
- R1: A display data access (device code A0h to write, A1h to read) targets physical address {segment[1:0], offset[7:0]}. Writing device code 60h on the display port loads its segment pointer from data bits [1:0], so all 1024 bytes are reachable.
- R2: A host data access targets physical address {bank, segment, offset[7:0]}. Writing device code 60h on the host port loads its one-bit segment pointer from data bit 0.
- R3: The bank bit is computed from the configuration register and the select pin. When configuration bit 2 is 1, the bank bit is configuration bit 1 XOR the select pin. When configuration bit 2 is 0, the bank bit is configuration bit 1 alone. A bank bit of 1 selects the upper bank (physical addresses 200h to 3FFh).
- R4: The configuration register resets to 00h. On the host port it is written with device code 62h and read back with device code 63h. On the display port, codes 62h and 63h are acknowledged, leave the register unchanged, and return 00h.
- R5: Both segment pointers are 0 after reset. A port's segment pointer returns to 0 when that port pulses its end-of-transaction input.
- R6: When configuration bit 0 is 0, a host write (code A0h) is acknowledged but leaves memory unchanged, and the host offset still advances by one.
- R7: Each port's offset is loaded by its offset-load pulse and advances by one after every data byte. It wraps from FFh to 00h without changing that port's segment pointer.
- R8: Display accesses return and store the same data whatever the select pin level and whatever the host port is doing at the same time.
- R9: At most one port is granted the memory in a cycle. When both ports request in the same cycle, one is served and the other is served in the next cycle. The grant alternates round-robin.
- R10: Acknowledge is a single-cycle pulse, one cycle after the operation is granted or accepted. Read data is valid in the acknowledge cycle and is 00h at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel_i | input | 1 | External bank select level |
| dsp_req | input | 1 | Display port operation request, held until acknowledged |
| dsp_dev | input | 8 | Display port device code (A0h, A1h, 60h) |
| dsp_wdata | input | 8 | Display port write data or segment value |
| dsp_ofs_ld | input | 1 | Display port offset load pulse |
| dsp_ofs | input | 8 | Display port offset value to load |
| dsp_end | input | 1 | Display port end-of-transaction pulse |
| dsp_ack | output | 1 | Display port acknowledge |
| dsp_rdata | output | 8 | Display port read data |
| hst_req | input | 1 | Host port operation request, held until acknowledged |
| hst_dev | input | 8 | Host port device code (A0h, A1h, 60h, 62h, 63h) |
| hst_wdata | input | 8 | Host port write data, segment or configuration value |
| hst_ofs_ld | input | 1 | Host port offset load pulse |
| hst_ofs | input | 8 | Host port offset value to load |
| hst_end | input | 1 | Host port end-of-transaction pulse |
| hst_ack | output | 1 | Host port acknowledge |
| hst_rdata | output | 8 | Host port read data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 10 | Memory physical address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_en |

## Verification
The assertions assume that the front ends hold a request steady until its acknowledge arrives. They also assume that the front ends never pulse offset-load or end-of-transaction in the same cycle as a request. Finally, they assume that the memory returns read data exactly one cycle after the strobe. The bench keeps within these assumptions by driving every operation through tasks that raise a request on a falling edge, wait for the acknowledge, and only then drop it. Offset loads and end pulses are issued in their own cycles between operations. In the concurrent phase, display writes are confined to segments 2 and 3 while the host reads only the lower bank. This means no read can race a write to the same byte.

// File: rtl/segmem_pkg.sv
package segmem_pkg;
   localparam logic [7:0] DEV_DATA_WR = 8'hA0;
   localparam logic [7:0] DEV_DATA_RD = 8'hA1;
   localparam logic [7:0] DEV_SEG_WR  = 8'h60;
   localparam logic [7:0] DEV_CFG_WR  = 8'h62;
   localparam logic [7:0] DEV_CFG_RD  = 8'h63;

   localparam int CFG_WEN_BIT  = 0;
   localparam int CFG_BANK_BIT = 1;
   localparam int CFG_PIN_BIT  = 2;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_MEM  = 2'd1,
      SRC_CFG  = 2'd2
   } rd_src_e;
endpackage

// File: rtl/segmem_cfg.sv
module segmem_cfg
   import segmem_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pin,
   output logic [DATA_W-1:0] cfg,
   output logic              wr_en,
   output logic              bank
);
   generate
      if (DATA_W < 3) begin : g_bad_width
         $error("segmem_cfg: DATA_W must hold three control bits");
      end
   endgenerate

   logic [DATA_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= '0;
      else if (wr) cfg_q <= wdata;
   end

   always_comb begin
      cfg   = cfg_q;
      wr_en = cfg_q[CFG_WEN_BIT];
      bank  = cfg_q[CFG_PIN_BIT] ? (cfg_q[CFG_BANK_BIT] ^ pin) : cfg_q[CFG_BANK_BIT];
   end

   // R4: the register only changes on a write strobe
   a_r4_cfg_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(cfg_q));
endmodule

// File: rtl/segmem_arb.sv
module segmem_arb #(
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mreq,
   output logic [1:0] gnt
);
   generate
      if (ROUND_ROBIN) begin : g_rr
         logic last_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    last_q <= 1'b1;
            else if (|gnt) last_q <= gnt[1];
         end
         always_comb begin
            if (&mreq) gnt = last_q ? 2'b01 : 2'b10;
            else       gnt = mreq;
         end
      end else begin : g_fixed
         always_comb begin
            if (&mreq) gnt = 2'b01;
            else       gnt = mreq;
         end
      end
   endgenerate

   a_r9_one_grant : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   a_r9_grant_needs_req : assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~mreq) == 2'b00);
   a_r9_no_idle_slot : assert property (@(posedge clk) disable iff (!rst_n)
      (|mreq) |-> (|gnt));
endmodule

// File: rtl/segmem_port.sv
module segmem_port
   import segmem_pkg::*;
#(
   parameter int OFS_W   = 8,
   parameter int SEG_W   = 2,
   parameter int DATA_W  = 8,
   parameter bit HAS_CFG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [7:0]        dev,
   input  logic [SEG_W-1:0]  seg_val,
   input  logic              ofs_ld,
   input  logic [OFS_W-1:0]  ofs_val,
   input  logic              xfer_end,
   input  logic              wr_allow,
   input  logic              grant,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] cfg_rdata,
   output logic              mreq,
   output logic              mwe,
   output logic              cfg_wr,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic [SEG_W-1:0]  seg,
   output logic [OFS_W-1:0]  ofs
);
   logic             ack_q;
   rd_src_e          src_q;
   rd_src_e          src_d;
   logic [SEG_W-1:0] seg_q;
   logic [OFS_W-1:0] ofs_q;
   logic acc, is_rd, is_wr, is_seg, is_cwr, is_crd, mem_op, done;

   generate
      if (HAS_CFG) begin : g_cfg
         assign is_cwr = (dev == DEV_CFG_WR);
         assign is_crd = (dev == DEV_CFG_RD);
      end else begin : g_nocfg
         assign is_cwr = 1'b0;
         assign is_crd = 1'b0;
      end
   endgenerate

   always_comb begin
      acc    = req & ~ack_q;
      is_rd  = (dev == DEV_DATA_RD);
      is_wr  = (dev == DEV_DATA_WR);
      is_seg = (dev == DEV_SEG_WR);
      mem_op = acc & (is_rd | (is_wr & wr_allow));
      done   = (mem_op & grant) | (acc & ~mem_op);
      mreq   = mem_op;
      mwe    = is_wr;
      cfg_wr = done & is_cwr;
      if (!done)      src_d = SRC_NONE;
      else if (is_rd) src_d = SRC_MEM;
      else if (is_crd) src_d = SRC_CFG;
      else            src_d = SRC_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         src_q <= SRC_NONE;
         seg_q <= '0;
         ofs_q <= '0;
      end else begin
         ack_q <= done;
         src_q <= src_d;
         if (xfer_end)            seg_q <= '0;
         else if (done & is_seg)  seg_q <= seg_val;
         if (ofs_ld)                       ofs_q <= ofs_val;
         else if (done & (is_rd | is_wr))  ofs_q <= ofs_q + 1'b1;
      end
   end

   always_comb begin
      ack = ack_q;
      seg = seg_q;
      ofs = ofs_q;
      case (src_q)
         SRC_MEM: rdata = mem_rdata;
         SRC_CFG: rdata = cfg_rdata;
         default: rdata = '0;
      endcase
   end

   a_r10_ack_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |=> !ack_q);
   a_r5_seg_clear : assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end |=> (seg_q == '0));
   a_r7_ofs_step : assert property (@(posedge clk) disable iff (!rst_n)
      (done && (is_rd || is_wr) && !ofs_ld) |=> (ofs_q == $past(ofs_q) + 1'b1));
   a_r10_quiet_rdata : assert property (@(posedge clk) disable iff (!rst_n)
      !ack_q |-> (rdata == '0));
endmodule

// File: rtl/segmem_access_ctrl.sv
module segmem_access_ctrl
   import segmem_pkg::*;
#(
   parameter int OFS_W       = 8,
   parameter int DSEG_W      = 2,
   parameter int DATA_W      = 8,
   parameter bit ROUND_ROBIN = 1'b1,
   localparam int HSEG_W     = DSEG_W - 1,
   localparam int ADDR_W     = OFS_W + DSEG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_sel_i,
   input  logic              dsp_req,
   input  logic [7:0]        dsp_dev,
   input  logic [DATA_W-1:0] dsp_wdata,
   input  logic              dsp_ofs_ld,
   input  logic [OFS_W-1:0]  dsp_ofs,
   input  logic              dsp_end,
   output logic              dsp_ack,
   output logic [DATA_W-1:0] dsp_rdata,
   input  logic              hst_req,
   input  logic [7:0]        hst_dev,
   input  logic [DATA_W-1:0] hst_wdata,
   input  logic              hst_ofs_ld,
   input  logic [OFS_W-1:0]  hst_ofs,
   input  logic              hst_end,
   output logic              hst_ack,
   output logic [DATA_W-1:0] hst_rdata,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   generate
      if (DSEG_W < 2) begin : g_bad_seg
         $error("segmem_access_ctrl: DSEG_W must be at least 2");
      end
      if (DSEG_W > DATA_W) begin : g_bad_data
         $error("segmem_access_ctrl: segment value wider than data byte");
      end
   endgenerate

   logic [1:0]        mreq, gnt;
   logic              dsp_mwe, hst_mwe, dsp_cfg_wr, hst_cfg_wr;
   logic [DSEG_W-1:0] dsp_seg;
   logic [HSEG_W-1:0] hst_seg;
   logic [OFS_W-1:0]  dsp_ofs_q, hst_ofs_q;
   logic [DATA_W-1:0] cfg;
   logic              cfg_wen, bank, cfg_wr;
   logic [DATA_W-1:0] cfg_wdata;

   assign cfg_wr    = dsp_cfg_wr | hst_cfg_wr;
   assign cfg_wdata = hst_cfg_wr ? hst_wdata : dsp_wdata;

   segmem_cfg #(.DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .pin(bank_sel_i), .cfg(cfg), .wr_en(cfg_wen), .bank(bank)
   );

   segmem_port #(.OFS_W(OFS_W), .SEG_W(DSEG_W), .DATA_W(DATA_W), .HAS_CFG(1'b0)) u_dsp (
      .clk(clk), .rst_n(rst_n), .req(dsp_req), .dev(dsp_dev),
      .seg_val(dsp_wdata[DSEG_W-1:0]), .ofs_ld(dsp_ofs_ld), .ofs_val(dsp_ofs),
      .xfer_end(dsp_end), .wr_allow(1'b1), .grant(gnt[0]),
      .mem_rdata(mem_rdata), .cfg_rdata(cfg),
      .mreq(mreq[0]), .mwe(dsp_mwe), .cfg_wr(dsp_cfg_wr),
      .ack(dsp_ack), .rdata(dsp_rdata), .seg(dsp_seg), .ofs(dsp_ofs_q)
   );

   segmem_port #(.OFS_W(OFS_W), .SEG_W(HSEG_W), .DATA_W(DATA_W), .HAS_CFG(1'b1)) u_hst (
      .clk(clk), .rst_n(rst_n), .req(hst_req), .dev(hst_dev),
      .seg_val(hst_wdata[HSEG_W-1:0]), .ofs_ld(hst_ofs_ld), .ofs_val(hst_ofs),
      .xfer_end(hst_end), .wr_allow(cfg_wen), .grant(gnt[1]),
      .mem_rdata(mem_rdata), .cfg_rdata(cfg),
      .mreq(mreq[1]), .mwe(hst_mwe), .cfg_wr(hst_cfg_wr),
      .ack(hst_ack), .rdata(hst_rdata), .seg(hst_seg), .ofs(hst_ofs_q)
   );

   segmem_arb #(.ROUND_ROBIN(ROUND_ROBIN)) u_arb (
      .clk(clk), .rst_n(rst_n), .mreq(mreq), .gnt(gnt)
   );

   always_comb begin
      mem_en = |gnt;
      if (gnt[1]) begin
         mem_we    = hst_mwe;
         mem_addr  = {bank, hst_seg, hst_ofs_q};
         mem_wdata = hst_wdata;
      end else begin
         mem_we    = gnt[0] & dsp_mwe;
         mem_addr  = {dsp_seg, dsp_ofs_q};
         mem_wdata = dsp_wdata;
      end
   end

   // R6: a host-side store never reaches memory while writes are disabled
   a_r6_host_write_gate : assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[1] && mem_we) |-> cfg[CFG_WEN_BIT]);
   // R9: a port is granted only when the other is not in the same cycle
   a_r9_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_ack && hst_ack) |-> !($past(mreq[0] & gnt[0]) && $past(mreq[1] & gnt[1])));
endmodule

// File: tb/tb_segmem_access_ctrl.sv
module tb_segmem_access_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin = 1'b0;
   always #5 clk = ~clk;

   logic       req [2];
   logic [7:0] dev [2];
   logic [7:0] wd  [2];
   logic       ld  [2];
   logic [7:0] ov  [2];
   logic       xe  [2];
   logic       ack [2];
   logic [7:0] rdt [2];
   logic       mem_en, mem_we;
   logic [9:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;

   segmem_access_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bank_sel_i(pin),
      .dsp_req(req[0]), .dsp_dev(dev[0]), .dsp_wdata(wd[0]), .dsp_ofs_ld(ld[0]),
      .dsp_ofs(ov[0]), .dsp_end(xe[0]), .dsp_ack(ack[0]), .dsp_rdata(rdt[0]),
      .hst_req(req[1]), .hst_dev(dev[1]), .hst_wdata(wd[1]), .hst_ofs_ld(ld[1]),
      .hst_ofs(ov[1]), .hst_end(xe[1]), .hst_ack(ack[1]), .hst_rdata(rdt[1]),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   logic [7:0] bmem [1024];
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) bmem[mem_addr] <= mem_wdata;
         mem_rdata <= bmem[mem_addr];
      end
   end

   int nchk = 0, nfail = 0, cyc = 0;
   int ack_cyc [2];
   logic [7:0] refm [1024];
   int mseg [2];
   int mofs [2];
   logic [7:0] mcfg = 8'h00;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         nfail++;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
      nchk++;
      if (a !== e) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
      end
   endtask

   function automatic logic bank_of(input logic [7:0] c, input logic p);
      return c[2] ? (c[1] ^ p) : c[1];
   endfunction

   function automatic int ea(input int p);
      if (p == 0) return mseg[0] * 256 + mofs[0];
      return int'(bank_of(mcfg, pin)) * 512 + mseg[1] * 256 + mofs[1];
   endfunction

   task automatic op(input int p, input logic [7:0] d, input logic [7:0] w, output logic [7:0] r);
      int n = 0;
      @(negedge clk);
      req[p] = 1'b1; dev[p] = d; wd[p] = w;
      do begin @(negedge clk); n++; end while (!ack[p] && n < 20);
      if (!ack[p]) chk("R10 ack timeout", 0, 1);
      ack_cyc[p] = cyc;
      r = rdt[p];
      req[p] = 1'b0;
      @(negedge clk);
      chk("R10 ack single pulse", {31'd0, ack[p]}, 0);
   endtask

   task automatic mwrite(input int p, input logic [7:0] v);
      logic [7:0] r;
      int a = ea(p);
      op(p, 8'hA0, v, r);
      if (p == 0 || mcfg[0]) refm[a] = v;
      mofs[p] = (mofs[p] + 1) % 256;
   endtask

   task automatic mread(input int p, input string tag);
      logic [7:0] r;
      int a = ea(p);
      op(p, 8'hA1, 8'h00, r);
      chk(tag, r, refm[a]);
      mofs[p] = (mofs[p] + 1) % 256;
   endtask

   task automatic setseg(input int p, input int s);
      logic [7:0] r;
      op(p, 8'h60, 8'(s), r);
      mseg[p] = (p == 0) ? (s & 3) : (s & 1);
   endtask

   task automatic ldofs(input int p, input int o);
      @(negedge clk); ld[p] = 1'b1; ov[p] = 8'(o);
      @(negedge clk); ld[p] = 1'b0;
      mofs[p] = o & 255;
   endtask

   task automatic xend(input int p);
      @(negedge clk); xe[p] = 1'b1;
      @(negedge clk); xe[p] = 1'b0;
      mseg[p] = 0;
   endtask

   task automatic setcfg(input logic [7:0] v);
      logic [7:0] r;
      op(1, 8'h62, v, r);
      mcfg = v;
   endtask

   initial begin
      logic [7:0] r;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 1024; i++) begin bmem[i] = 8'h00; refm[i] = 8'h00; end
      for (int p = 0; p < 2; p++) begin
         req[p] = 0; dev[p] = 0; wd[p] = 0; ld[p] = 0; ov[p] = 0; xe[p] = 0;
         mseg[p] = 0; mofs[p] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset dsp_ack", {31'd0, ack[0]}, 0);
      chk("R10 reset hst_ack", {31'd0, ack[1]}, 0);
      chk("R9 reset mem_en", {31'd0, mem_en}, 0);
      chk("R10 reset rdata", {16'd0, rdt[0], rdt[1]}, 0);
      op(1, 8'h63, 8'h00, r);
      chk("R4 cfg reset value", r, 8'h00);

      // R1: fill every segment at offset 10h from the display side
      for (int s = 0; s < 4; s++) begin
         setseg(0, s); ldofs(0, 16); mwrite(0, 8'(8'h40 + s)); xend(0);
      end
      for (int s = 0; s < 4; s++) begin
         setseg(0, s); ldofs(0, 16); mread(0, "R1 display segment map"); xend(0);
      end

      // R2/R3: host bank and segment mapping over every select combination
      for (int c = 0; c < 4; c++) begin
         setcfg(8'(c << 1));
         for (int pv = 0; pv < 2; pv++) begin
            for (int hs = 0; hs < 2; hs++) begin
               @(negedge clk); pin = pv[0];
               setseg(1, hs); ldofs(1, 16);
               op(1, 8'hA1, 8'h00, r);
               chk("R3 bank select", r,
                   8'(8'h40 + int'(bank_of(mcfg, pin)) * 2 + hs));
               mofs[1]++;
               xend(1);
            end
         end
      end
      pin = 1'b0;

      // R4: config readback, and display cannot touch it
      setcfg(8'h05);
      op(1, 8'h63, 8'h00, r);
      chk("R4 cfg readback", r, 8'h05);
      op(0, 8'h62, 8'h00, r);
      op(0, 8'h63, 8'h00, r);
      chk("R4 display cfg read returns zero", r, 8'h00);
      op(1, 8'h63, 8'h00, r);
      chk("R4 display cfg write ignored", r, 8'h05);

      // R6: disabled host write leaves memory, offset still advances
      setcfg(8'h00);
      setseg(1, 0); ldofs(1, 32);
      refm[33] = 8'h00;
      mwrite(1, 8'hEE);
      mread(1, "R6 host offset advanced past blocked write");
      setseg(0, 0); ldofs(0, 32);
      op(0, 8'hA1, 8'h00, r);
      chk("R6 blocked write left memory", r, 8'h00);
      mofs[0]++;
      setcfg(8'h01);
      ldofs(1, 32); mwrite(1, 8'h5A);
      ldofs(0, 32); mread(0, "R6 enabled host write stored");
      xend(0); xend(1);

      // R5 and R7: pointer clear on end, wrap without segment carry
      setseg(0, 1); ldofs(0, 255);
      mwrite(0, 8'hA5); mwrite(0, 8'h3C);
      ldofs(0, 0); mread(0, "R7 wrap stays in segment 1");
      xend(0);
      ldofs(0, 0); mread(0, "R5 display segment back to 0");
      setseg(1, 1); ldofs(1, 255);
      mwrite(1, 8'h11); mwrite(1, 8'h22);
      ldofs(1, 0); mread(1, "R7 host wrap stays in segment 1");
      xend(1);
      ldofs(1, 0); mread(1, "R5 host segment back to 0");

      // R9: simultaneous memory requests are served in consecutive cycles
      for (int k = 0; k < 3; k++) begin
         setseg(0, 3); ldofs(0, 16); ldofs(1, 16); setseg(1, 0);
         fork
            mread(0, "R9 contended display read");
            mread(1, "R9 contended host read");
         join
         chk("R9 one grant per cycle",
             (ack_cyc[0] > ack_cyc[1]) ? ack_cyc[0] - ack_cyc[1] : ack_cyc[1] - ack_cyc[0], 1);
         xend(0); xend(1);
      end

      // random sequential traffic on both ports
      for (int i = 0; i < 400; i++) begin
         int p = int'($urandom % 2);
         int k = int'($urandom % 8);
         case (k)
            0: setseg(p, int'($urandom % 4));
            1: ldofs(p, int'($urandom % 256));
            2, 3: mwrite(p, 8'($urandom));
            4, 5: mread(p, p == 0 ? "R1 random display read" : "R2 random host read");
            6: xend(p);
            default: begin
               if (p == 1) setcfg(8'($urandom % 8));
               else begin @(negedge clk); pin = ~pin; end
            end
         endcase
      end

      // R8: concurrent traffic with the select pin moving
      setcfg(8'h00); xend(0); xend(1);
      fork
         for (int i = 0; i < 120; i++) begin
            int k = int'($urandom % 5);
            if (k == 0) setseg(0, int'($urandom % 4));
            else if (k == 1) ldofs(0, int'($urandom % 256));
            else if (k == 2 && mseg[0] >= 2) mwrite(0, 8'($urandom));
            else mread(0, "R8 display under host traffic");
         end
         for (int i = 0; i < 120; i++) begin
            int k = int'($urandom % 4);
            if (k == 0) setseg(1, int'($urandom % 2));
            else if (k == 1) ldofs(1, int'($urandom % 256));
            else mread(1, "R9 host under display traffic");
         end
         repeat (600) begin
            @(negedge clk);
            if ($urandom % 4 == 0) pin = ~pin;
         end
      join

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule